// File: doc/BRIEF.md
# Multiply-Accumulate Unit

This block multiplies two 16-bit operands in one clock cycle and either loads the product into a 40-bit accumulator or adds it to or subtracts it from the value already held there. Each operand has its own signedness select, so signed×signed, signed×unsigned and unsigned×unsigned products all use the same datapath. The 32-bit product is sign-extended into the 40-bit accumulator, which leaves eight guard bits, so a long run of accumulations can exceed the 32-bit range without losing the true sum.

The accumulator is registered once. An operation accepted on one rising edge is visible on the outputs right after that edge, so the result can feed the next operation directly. The accumulator is shown as three fields: the guard byte, the high word and the low word. A 32-bit read-out clamps to the nearest 32-bit limit whenever the guard bits hold significant data, and an overflow flag marks that condition. An optional round-to-nearest step can be requested with any arithmetic operation.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low the accumulator is zero, and it stays zero on the first cycle after release until an operation is accepted.
- R2: Opcode 2'b00 (load) with `in_valid` high replaces the accumulator with the sign-extended product.
- R3: When `a_signed` (or `b_signed`) is 1 the operand is read as two's complement, otherwise as an unsigned value from 0 to 65535. The product is exact and sign-extended to 40 bits.
- R4: Opcode 2'b01 (accumulate) adds the product to the accumulator.
- R5: Opcode 2'b10 (deduct) subtracts the product from the accumulator.
- R6: Opcode 2'b11 (clear) sets the accumulator to zero and ignores `round_en` and the operands.
- R7: While `in_valid` is low the accumulator keeps its value, whatever the other inputs are.
- R8: The result of an operation accepted on a rising edge appears on every output right after that edge, with no further delay.
- R9: `acc_guard` is accumulator bits 39:32, `acc_hi` is bits 31:16 and `acc_lo` is bits 15:0.
- R10: `ovf` is 1 exactly when accumulator bits 39 down to 31 are not all equal.
- R11: When `ovf` is 0, `sat_out` equals accumulator bits 31:0. When `ovf` is 1, `sat_out` is 32'h7FFFFFFF if bit 39 is 0 and 32'h80000000 if bit 39 is 1.
- R12: With `round_en` high on opcodes 00, 01 or 10, 40'h8000 is added to the arithmetic result and bits 15:0 are then cleared before the value is stored.
- R13: Accumulator arithmetic wraps modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Accept an operation on this edge |
| op | input | 2 | 00 load, 01 accumulate, 10 deduct, 11 clear |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| a_signed | input | 1 | First operand is two's complement |
| b_signed | input | 1 | Second operand is two's complement |
| round_en | input | 1 | Round result to nearest high word |
| acc_guard | output | 8 | Accumulator bits 39:32 |
| acc_hi | output | 16 | Accumulator bits 31:16 |
| acc_lo | output | 16 | Accumulator bits 15:0 |
| sat_out | output | 32 | Saturated 32-bit read-out |
| ovf | output | 1 | Guard bits hold significant data |

## Verification
The bench targets the unsigned product 0xFFFF×0xFFFF. It does not overflow 40 bits, but it sets bit 31 with zero guard bits, so the read-out must clamp. A design that sign-extends an unsigned product would instead report a small negative value. Mixed-sign products such as -1×65535 catch a design that treats both operands as signed, which would give +1. More than 512 accumulations of 2^30 drive the accumulator through the positive clamp region and past the 40-bit wrap, which exposes a narrow guard or a wrong clamp polarity. Round-to-nearest is tried just below and exactly at the half-way point, where a design that truncates or forgets to clear the low word reads back a wrong high word.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        MAC_OP_LOAD = 2'b00,
        MAC_OP_ACC  = 2'b01,
        MAC_OP_DED  = 2'b10,
        MAC_OP_CLR  = 2'b11
    } mac_op_e;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
    parameter int DATA_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              a_signed,
    input  logic              b_signed,
    output logic [ACC_W-1:0]  prod_ext
);
    localparam int XW  = DATA_W + 1;
    localparam int PW  = 2 * XW;
    localparam int EXT = ACC_W - PW;

    logic signed [XW-1:0] a_x;
    logic signed [XW-1:0] b_x;
    logic signed [PW-1:0] prod;

    always_comb begin
        a_x  = {a_signed & a[DATA_W-1], a};
        b_x  = {b_signed & b[DATA_W-1], b};
        prod = a_x * b_x;
    end

    generate
        if (EXT > 0) begin : g_ext
            assign prod_ext = {{EXT{prod[PW-1]}}, prod};
        end else begin : g_trunc
            assign prod_ext = prod[ACC_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/mac_accum.sv
module mac_accum
    import mac_pkg::*;
#(
    parameter int ACC_W = 40,
    parameter int RND_W = 16
) (
    input  logic [ACC_W-1:0] acc_cur,
    input  logic [ACC_W-1:0] prod_ext,
    input  mac_op_e          op,
    input  logic             round_en,
    output logic [ACC_W-1:0] acc_next
);
    localparam logic [ACC_W-1:0] RND_BIAS = ACC_W'(1) << (RND_W - 1);
    localparam logic [ACC_W-1:0] RND_MASK = ~((ACC_W'(1) << RND_W) - ACC_W'(1));

    logic [ACC_W-1:0] sum;

    always_comb begin
        case (op)
            MAC_OP_LOAD: sum = prod_ext;
            MAC_OP_ACC:  sum = acc_cur + prod_ext;
            MAC_OP_DED:  sum = acc_cur - prod_ext;
            default:     sum = '0;
        endcase
        if (round_en && op != MAC_OP_CLR) begin
            acc_next = (sum + RND_BIAS) & RND_MASK;
        end else begin
            acc_next = sum;
        end
    end
endmodule

// File: rtl/mac_sat.sv
module mac_sat #(
    parameter int ACC_W  = 40,
    parameter int PROD_W = 32
) (
    input  logic [ACC_W-1:0]  acc,
    output logic              ovf,
    output logic [PROD_W-1:0] sat_out
);
    localparam int TOP_W = ACC_W - PROD_W + 1;
    localparam logic [PROD_W-1:0] POS_LIM = {1'b0, {(PROD_W-1){1'b1}}};
    localparam logic [PROD_W-1:0] NEG_LIM = {1'b1, {(PROD_W-1){1'b0}}};

    logic [TOP_W-1:0] top;

    always_comb begin
        top = acc[ACC_W-1:PROD_W-1];
        ovf = !((&top) || (~|top));
        if (!ovf) begin
            sat_out = acc[PROD_W-1:0];
        end else if (acc[ACC_W-1]) begin
            sat_out = NEG_LIM;
        end else begin
            sat_out = POS_LIM;
        end
    end
endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    input  logic                a_signed,
    input  logic                b_signed,
    input  logic                round_en,
    output logic [GUARD_W-1:0]  acc_guard,
    output logic [DATA_W-1:0]   acc_hi,
    output logic [DATA_W-1:0]   acc_lo,
    output logic [2*DATA_W-1:0] sat_out,
    output logic                ovf
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int ACC_W  = PROD_W + GUARD_W;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
    } mac_state_t;

    mac_state_t st_d, st_q;

    logic [ACC_W-1:0] prod_ext;
    logic [ACC_W-1:0] acc_next;

    mac_mult #(.DATA_W(DATA_W), .ACC_W(ACC_W)) mult_i (
        .a        (a),
        .b        (b),
        .a_signed (a_signed),
        .b_signed (b_signed),
        .prod_ext (prod_ext)
    );

    mac_accum #(.ACC_W(ACC_W), .RND_W(DATA_W)) accum_i (
        .acc_cur  (st_q.acc),
        .prod_ext (prod_ext),
        .op       (mac_op_e'(op)),
        .round_en (round_en),
        .acc_next (acc_next)
    );

    mac_sat #(.ACC_W(ACC_W), .PROD_W(PROD_W)) sat_i (
        .acc     (st_q.acc),
        .ovf     (ovf),
        .sat_out (sat_out)
    );

    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            st_d.acc = acc_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_guard = st_q.acc[ACC_W-1:PROD_W];
    assign acc_hi    = st_q.acc[PROD_W-1:DATA_W];
    assign acc_lo    = st_q.acc[DATA_W-1:0];
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic [1:0]          op,
    input logic [DATA_W-1:0]   a,
    input logic [DATA_W-1:0]   b,
    input logic                a_signed,
    input logic                b_signed,
    input logic                round_en,
    input logic [GUARD_W-1:0]  acc_guard,
    input logic [DATA_W-1:0]   acc_hi,
    input logic [DATA_W-1:0]   acc_lo,
    input logic [2*DATA_W-1:0] sat_out,
    input logic                ovf
);
    localparam logic [2*DATA_W-1:0] POS_LIM = {1'b0, {(2*DATA_W-1){1'b1}}};
    localparam logic [2*DATA_W-1:0] NEG_LIM = {1'b1, {(2*DATA_W-1){1'b0}}};

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable({acc_guard, acc_hi, acc_lo}));

    // R6
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b11) |=> ({acc_guard, acc_hi, acc_lo} == '0 && !ovf));

    // R12
    round_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && round_en) |=> (acc_lo == '0));

    // R2
    signed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 2'b00 && a_signed && b_signed && !round_en) |=> !ovf);

    // R11
    sat_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf |-> (sat_out == {acc_hi, acc_lo}));

    // R11
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (sat_out == (acc_guard[GUARD_W-1] ? NEG_LIM : POS_LIM)));

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> ({acc_guard, acc_hi, acc_lo} == '0));
endmodule

bind mac_unit mac_unit_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .b         (b),
    .a_signed  (a_signed),
    .b_signed  (b_signed),
    .round_en  (round_en),
    .acc_guard (acc_guard),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .sat_out   (sat_out),
    .ovf       (ovf)
);

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = 2'b00;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        round_en = 1'b0;
    logic [7:0]  acc_guard;
    logic [15:0] acc_hi;
    logic [15:0] acc_lo;
    logic [31:0] sat_out;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    logic [39:0] model = '0;
    logic [39:0] exp_q[$];
    string       tag_q[$];
    logic        taken = 1'b0;

    always #10 clk = ~clk;

    mac_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .a(a), .b(b), .a_signed(a_signed), .b_signed(b_signed),
        .round_en(round_en), .acc_guard(acc_guard), .acc_hi(acc_hi),
        .acc_lo(acc_lo), .sat_out(sat_out), .ovf(ovf)
    );

    function automatic logic [39:0] ref_prod(logic [15:0] x, logic [15:0] y,
                                             logic xs, logic ys);
        longint sx = longint'(x);
        longint sy = longint'(y);
        if (xs && x[15]) sx = sx - 65536;
        if (ys && y[15]) sy = sy - 65536;
        return 40'(sx * sy);
    endfunction

    task automatic compare(logic [39:0] e, string tag);
        logic [31:0] es;
        logic        eo;
        eo = !((e[39:31] == 9'h1FF) || (e[39:31] == 9'h000));
        es = !eo ? e[31:0] : (e[39] ? 32'h8000_0000 : 32'h7FFF_FFFF);
        checks++;
        if ({acc_guard, acc_hi, acc_lo} !== e || ovf !== eo || sat_out !== es) begin
            errors++;
            $display("FAIL %s: acc=%h ovf=%b sat=%h expected acc=%h ovf=%b sat=%h",
                     tag, {acc_guard, acc_hi, acc_lo}, ovf, sat_out, e, eo, es);
        end
    endtask

    // monitor: pop one expected item per accepted operation
    always @(posedge clk) taken <= rst_n && in_valid;

    always @(negedge clk) begin
        if (taken) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8: result without expected item, actual=%h expected=none",
                         {acc_guard, acc_hi, acc_lo});
            end else begin
                compare(exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    // driver: call at a negedge; leaves in_valid high for the next posedge
    task automatic issue(logic [1:0] o, logic [15:0] x, logic [15:0] y,
                         logic xs, logic ys, logic rnd, string tag);
        logic [39:0] p;
        p = ref_prod(x, y, xs, ys);
        case (o)
            2'b00: model = p;
            2'b01: model = model + p;
            2'b10: model = model - p;
            default: model = '0;
        endcase
        if (rnd && o != 2'b11) begin
            model = model + 40'h8000;
            model[15:0] = '0;
        end
        in_valid = 1'b1; op = o; a = x; b = y;
        a_signed = xs; b_signed = ys; round_en = rnd;
        exp_q.push_back(model);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        in_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            op = 2'($urandom); a = 16'($urandom); b = 16'($urandom);
            a_signed = 1'($urandom); b_signed = 1'($urandom); round_en = 1'($urandom);
            @(negedge clk);
            compare(model, tag);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (2) @(negedge clk);
        compare(40'h0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(40'h0, "R1 after release");

        issue(2'b00, 16'd3, 16'hFFFC, 1'b1, 1'b1, 1'b0, "R2 R3 signed load 3*-4");
        issue(2'b00, 16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R3 R10 R11 unsigned max");
        issue(2'b00, 16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, "R3 mixed -1*65535");
        issue(2'b00, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, "R3 R9 most negative squared");
        issue(2'b01, 16'd1000, 16'd2000, 1'b1, 1'b1, 1'b0, "R4 accumulate");
        issue(2'b10, 16'd7, 16'hFFFB, 1'b1, 1'b1, 1'b0, "R5 deduct negative");
        issue(2'b10, 16'h7FFF, 16'h7FFF, 1'b0, 1'b1, 1'b0, "R5 deduct positive");
        idle(3, "R7 hold while idle");
        issue(2'b11, 16'h1234, 16'h5678, 1'b1, 1'b1, 1'b1, "R6 clear ignores round");

        for (int i = 0; i < 520; i++)
            issue(2'b01, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, "R10 R11 R13 positive run");
        issue(2'b11, 16'h0, 16'h0, 1'b0, 1'b0, 1'b0, "R6 clear");
        for (int i = 0; i < 3; i++)
            issue(2'b10, 16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, "R5 R11 negative clamp");

        issue(2'b00, 16'd1, 16'h7FFF, 1'b0, 1'b0, 1'b1, "R12 round below half");
        issue(2'b00, 16'd1, 16'h8000, 1'b0, 1'b0, 1'b1, "R12 round at half");
        issue(2'b01, 16'd3, 16'h5555, 1'b0, 1'b0, 1'b1, "R12 round on accumulate");
        issue(2'b10, 16'hFFFF, 16'h0003, 1'b1, 1'b0, 1'b1, "R12 round on deduct");
        issue(2'b01, 16'h1234, 16'h0101, 1'b0, 1'b0, 1'b0, "R8 back to back");
        idle(2, "R7 hold after round");

        in_valid = 1'b0;
        rst_n = 1'b0;
        model = '0;
        @(negedge clk);
        compare(40'h0, "R1 mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare(40'h0, "R1 second release");

        repeat (2) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8: pending results actual=%0d expected=0", exp_q.size());
        end
        summary();
    end
endmodule